// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time in packed BCD: a 7-bit sub-second counter advanced by a 128 Hz tick strobe, then seconds, minutes, hours, day of week, day of month, month, year and, when built with the option, a century byte. Each sub-second wrap adds one second, and the carry ripples through the calendar. Month lengths and the leap-year rule are applied on the way.

Software reaches every counter and two control registers over a byte-wide register port. To set the clock, software stops the counters and clears the prescaler, writes the fields, then sets enable and start. A sticky carry flag tells software that a seconds carry happened, for example while it was reading the fields. Combined with its enable bit, that flag drives the interrupt output. A one-shot adjust command rounds the time to the nearest minute.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the counters hold 00:00:00, weekday 0, day 01, month 01, year 00 and century 20 (address 16). Both control registers read 0x00 and irq is low.
- R2: While control-2 bit 0 (start) or bit 3 (enable) is clear, tick pulses leave the sub-second counter (address 0) and all time fields unchanged.
- R3: While start and enable are both set, each cycle with tick high advances the 7-bit sub-second counter by one.
- R4: When the sub-second counter wraps from 127 to 0, the seconds advance and control-1 bit 7 (carry flag) is set on the same edge. irq equals the carry flag ANDed with control-1 bit 4.
- R5: Writing control 1 with bit 7 = 1 leaves the carry flag as it was. Writing it with bit 7 = 0 clears the flag, unless a carry occurs on that same edge.
- R6: Seconds and minutes wrap at 59, hours at 23, weekday from 6 to 0, month from 12 to 01, and year from 99 to 00. The year wrap increments the century.
- R7: The day of month wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months except February, and the month then advances.
- R8: February ends at day 29 when the BCD year (address 7) is divisible by 4, year 00 included, and at day 28 otherwise.
- R9: Writing control 2 with bit 2 set clears the seconds to 00. If the seconds were 30 or more, it also increments the minute with full carry into the hours and beyond.
- R10: Writing control 2 with bit 1 set clears the sub-second counter. Bits 1 and 2 of control 2 always read back as 0.
- R11: A write to a time field (addresses 1 to 7, 16) takes effect on the next edge. A tick in the same cycle is dropped: the sub-second counter does not advance and no carry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at 128 Hz |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address: 0 sub-second, 1..7 sec..year, 14 control 1, 15 control 2, 16 century |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Carry interrupt |

## Verification
Register writes and tick pulses are applied on the falling clock edge and take effect on the following rising edge. A seconds rollover and the carry flag, with irq that follows it, therefore appear on the same rising edge as the 128th tick. Ripple into the minutes, hours, days, months and years lands on that same edge. Each expected value is queued after the stimulus has completed, and the monitor compares it a nanosecond after the next falling edge, once the combinational read mux has settled.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter bit         CENTURY_EN   = 1'b1,
  parameter logic [7:0] CENTURY_INIT = 8'h20,
  parameter int         SUB_W        = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam logic [SUB_W-1:0] SUB_LAST = '1;

  logic [SUB_W-1:0] sub;
  logic [7:0] sec, min, hr, wday, day, mon, yr, cen;
  logic cf, cie, start, en;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  wire run     = start & en;
  wire ctl1_wr = wr_en && addr == 5'd14;
  wire ctl2_wr = wr_en && addr == 5'd15;
  wire prst    = ctl2_wr & wdata[1];
  wire adj     = ctl2_wr & wdata[2];
  wire time_wr = wr_en && ((addr >= 5'd1 && addr <= 5'd7) || (CENTURY_EN && addr == 5'd16));
  wire adv     = run & tick & ~time_wr & ~prst;
  wire carry   = adv && sub == SUB_LAST;

  wire [1:0] leap_sum = {yr[4], 1'b0} + yr[1:0];
  wire       leap     = leap_sum == 2'd0;
  logic [7:0] last_day;
  always_comb begin
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  wire inc_min = (adj && sec >= 8'h30) || (carry && sec == 8'h59);
  wire inc_hr  = inc_min && min == 8'h59;
  wire inc_day = inc_hr && hr == 8'h23;
  wire inc_mon = inc_day && day == last_day;
  wire inc_yr  = inc_mon && mon == 8'h12;
  wire inc_cen = inc_yr && yr == 8'h99;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub <= '0;
      sec <= 8'h00; min <= 8'h00; hr <= 8'h00; wday <= 8'h00;
      day <= 8'h01; mon <= 8'h01; yr <= 8'h00; cen <= CENTURY_INIT;
      cf <= 1'b0; cie <= 1'b0; start <= 1'b0; en <= 1'b0;
    end else begin
      if (prst)     sub <= '0;
      else if (adv) sub <= sub + 1'b1;
      cf <= carry | (cf & ~(ctl1_wr & ~wdata[7]));
      if (ctl1_wr) cie <= wdata[4];
      if (ctl2_wr) begin
        start <= wdata[0];
        en    <= wdata[3];
      end
      if (time_wr) begin
        case (addr)
          5'd1:    sec  <= wdata;
          5'd2:    min  <= wdata;
          5'd3:    hr   <= wdata;
          5'd4:    wday <= wdata;
          5'd5:    day  <= wdata;
          5'd6:    mon  <= wdata;
          5'd7:    yr   <= wdata;
          default: cen  <= wdata;
        endcase
      end else begin
        if (adj)        sec <= 8'h00;
        else if (carry) sec <= (sec == 8'h59) ? 8'h00 : bcd_inc(sec);
        if (inc_min) min <= (min == 8'h59) ? 8'h00 : bcd_inc(min);
        if (inc_hr)  hr  <= (hr == 8'h23) ? 8'h00 : bcd_inc(hr);
        if (inc_day) begin
          wday <= (wday == 8'h06) ? 8'h00 : wday + 8'd1;
          day  <= (day == last_day) ? 8'h01 : bcd_inc(day);
        end
        if (inc_mon) mon <= (mon == 8'h12) ? 8'h01 : bcd_inc(mon);
        if (inc_yr)  yr  <= (yr == 8'h99) ? 8'h00 : bcd_inc(yr);
        if (inc_cen && CENTURY_EN) cen <= bcd_inc(cen);
      end
    end
  end

  always_comb begin
    case (addr)
      5'd0:    rdata = 8'(sub);
      5'd1:    rdata = sec;
      5'd2:    rdata = min;
      5'd3:    rdata = hr;
      5'd4:    rdata = wday;
      5'd5:    rdata = day;
      5'd6:    rdata = mon;
      5'd7:    rdata = yr;
      5'd14:   rdata = {cf, 2'b00, cie, 4'b0000};
      5'd15:   rdata = {4'b0000, en, 2'b00, start};
      5'd16:   rdata = CENTURY_EN ? cen : 8'h00;
      default: rdata = 8'h00;
    endcase
  end

  assign irq = cf & cie;
endmodule

module bcd_rtc_core_chk #(parameter int SUB_W = 7) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [4:0]       addr,
  input logic [7:0]       wdata,
  input logic [SUB_W-1:0] sub,
  input logic             cf,
  input logic             run,
  input logic             time_wr
);
  wire prst = wr_en && addr == 5'd15 && wdata[1];

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !prst) |=> $stable(sub));
  a_r3_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !time_wr && !prst) |=> sub == SUB_W'($past(sub) + 1'b1));
  a_r4_cf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !time_wr && !prst && sub == {SUB_W{1'b1}}) |=> cf);
  a_r5_cf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cf && !(wr_en && addr == 5'd14 && !wdata[7])) |=> cf);
  a_r10_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    prst |=> sub == '0);
  a_r11_write_drops_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (time_wr && tick) |=> ($stable(sub) && !$rose(cf)));
endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.SUB_W(SUB_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .sub(sub), .cf(cf), .run(run), .time_wr(time_wr)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int total = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {bit is_irq; logic [4:0] a; logic [7:0] e; string tag;} item_t;
  item_t q[$];

  always #2 clk = ~clk;

  bcd_rtc_core dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always begin
    @(negedge clk);
    #1;
    if (q.size() != 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_irq ? {7'd0, irq} : rdata;
      total++;
      if (act !== it.e) begin
        fails++;
        $display("FAIL %s addr %0d: actual %h expected %h", it.tag, it.a, act, it.e);
      end
    end
  end

  task automatic chk(input logic [4:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_irq = 1'b0; it.a = a; it.e = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.a = 5'd0; it.e = {7'd0, e}; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic tk = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y);
    wr(5'd15, 8'h02);
    wr(5'd1, s); wr(5'd2, m); wr(5'd3, h); wr(5'd4, w);
    wr(5'd5, d); wr(5'd6, mo); wr(5'd7, y);
    wr(5'd15, 8'h09);
  endtask

  task automatic roll_day(input logic [7:0] d, mo, y, ed, emo, input string tag);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, d, mo, y);
    ticks(128);
    chk(5'd5, ed, tag);
    chk(5'd6, emo, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(5'd15, 8'h00, "R1");
    chk(5'd14, 8'h00, "R1");
    chk(5'd5, 8'h01, "R1");
    chk(5'd6, 8'h01, "R1");
    chk(5'd16, 8'h20, "R1");
    chk(5'd1, 8'h00, "R1");
    chk_irq(1'b0, "R1");
    // R2 stopped counters ignore ticks
    ticks(10);
    chk(5'd0, 8'h00, "R2");
    chk(5'd1, 8'h00, "R2");
    wr(5'd15, 8'h01);
    ticks(4);
    chk(5'd0, 8'h00, "R2");
    // R3 counting
    set_time(8'h58, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    ticks(5);
    chk(5'd0, 8'h05, "R3");
    // R4 carry on wrap
    ticks(123);
    chk(5'd0, 8'h00, "R4");
    chk(5'd1, 8'h59, "R4");
    chk(5'd14, 8'h80, "R4");
    chk_irq(1'b0, "R4");
    // R5 write 1 keeps flag; R4 irq with enable
    wr(5'd14, 8'h90);
    chk(5'd14, 8'h90, "R5");
    chk_irq(1'b1, "R4");
    wr(5'd14, 8'h10);
    chk(5'd14, 8'h10, "R5");
    chk_irq(1'b0, "R5");
    // R11 write with coincident tick
    ticks(127);
    chk(5'd0, 8'h7f, "R11");
    wr(5'd1, 8'h10, 1'b1);
    chk(5'd1, 8'h10, "R11");
    chk(5'd0, 8'h7f, "R11");
    chk(5'd14, 8'h10, "R11");
    ticks(1);
    chk(5'd1, 8'h11, "R11");
    chk(5'd14, 8'h90, "R11");
    wr(5'd14, 8'h00);
    // R6 full rollover
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    wr(5'd16, 8'h20);
    ticks(128);
    chk(5'd1, 8'h00, "R6");
    chk(5'd2, 8'h00, "R6");
    chk(5'd3, 8'h00, "R6");
    chk(5'd4, 8'h00, "R6");
    chk(5'd5, 8'h01, "R6");
    chk(5'd6, 8'h01, "R6");
    chk(5'd7, 8'h00, "R6");
    chk(5'd16, 8'h21, "R6");
    // R7 month lengths
    roll_day(8'h30, 8'h04, 8'h23, 8'h01, 8'h05, "R7");
    roll_day(8'h30, 8'h01, 8'h23, 8'h31, 8'h01, "R7");
    roll_day(8'h31, 8'h01, 8'h23, 8'h01, 8'h02, "R7");
    roll_day(8'h30, 8'h11, 8'h23, 8'h01, 8'h12, "R7");
    roll_day(8'h15, 8'h06, 8'h23, 8'h16, 8'h06, "R7");
    chk(5'd4, 8'h04, "R7");
    // R8 leap years
    roll_day(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R8");
    roll_day(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R8");
    roll_day(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R8");
    roll_day(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R8");
    roll_day(8'h28, 8'h02, 8'h18, 8'h01, 8'h03, "R8");
    // R9 adjust
    set_time(8'h29, 8'h10, 8'h05, 8'h00, 8'h01, 8'h01, 8'h00);
    wr(5'd15, 8'h0d);
    chk(5'd1, 8'h00, "R9");
    chk(5'd2, 8'h10, "R9");
    chk(5'd15, 8'h09, "R10");
    set_time(8'h45, 8'h59, 8'h05, 8'h00, 8'h01, 8'h01, 8'h00);
    wr(5'd15, 8'h0d);
    chk(5'd1, 8'h00, "R9");
    chk(5'd2, 8'h00, "R9");
    chk(5'd3, 8'h06, "R9");
    // R10 prescaler reset while running
    ticks(7);
    chk(5'd0, 8'h07, "R10");
    wr(5'd15, 8'h0b);
    chk(5'd0, 8'h00, "R10");
    chk(5'd15, 8'h09, "R10");
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule